// File: doc/BRIEF.md
# Bridge Address and Requester-ID Translator

This block joins two isolated memory domains. It looks at the memory read and write requests that arrive on the primary side. A request whose address falls inside one of a small set of programmable windows is forwarded to the secondary side. On the way, its address is moved into the secondary space, to the window's programmed target plus the request's offset inside the window. The requester ID of every forwarded request is replaced through a small ID table. Traffic can only flow from primary to secondary, and only through a window that is switched on and an ID entry that is valid. Anything else is dropped and reported on an unsupported-request strobe, together with a cause code.

A single configuration write port programs the windows and the ID table. Each write is held in a one-deep pending slot. It takes effect only when no translated request is waiting on the secondary side. While a write is pending, the primary side is stalled, so a request is always translated against one consistent set of settings.

Top module: `xlat_bridge`

## Requirements
- R1: A primary request accepted on a rising edge, whose address lies in an enabled window of size 2^k, appears on the secondary side after that edge with address = (target with its low k bits cleared) + (address mod 2^k). The low k bits of the programmed base are ignored.
- R2: When several enabled windows contain the address, the window with the lowest index decides the translation.
- R3: A forwarded request carries the replacement ID of the lowest-index valid ID-table entry whose source ID equals its requester ID. Its data and write flag pass unchanged.
- R4: An accepted request that hits no enabled window is not forwarded. ur_valid is high for the one cycle after the accepting edge, with ur_cause = 2'b01. ur_cause is 2'b00 whenever ur_valid is low.
- R5: An accepted request that hits a window but has no matching valid ID entry is not forwarded. It is flagged with ur_cause = 2'b10. When both the window and the ID miss, the cause is 2'b01.
- R6: A disabled window and an invalid ID-table entry never match.
- R7: Register map. When cfg_addr[7:4] = 0, window cfg_addr[3:2] is written:
  - field cfg_addr[1:0] = 0 is the base;
  - field 1 is the target;
  - field 2 is control: bit 0 is enable, bits 12:8 hold k.
  When cfg_addr[7:4] = 1, ID entry cfg_addr[3:1] is written:
  - cfg_addr[0] = 0 holds the source ID in bits 15:0 and the valid flag in bit 16;
  - cfg_addr[0] = 1 holds the replacement ID in bits 15:0.
  Every other address, including field 3 of a window, changes nothing.
- R8: A configuration write is taken when cfg_valid and cfg_ready are both high. It stays pending until the first rising edge at which no secondary request is held, and is applied on that edge. While it is pending, cfg_ready and pri_ready are low. A request accepted earlier keeps the translation of the old settings.
- R9: While sec_valid is high and sec_ready is low, the secondary outputs hold still and pri_ready is low.
- R10: After reset, sec_valid and ur_valid are low, pri_ready and cfg_ready are high, every window is disabled and every ID entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_valid | input | 1 | Primary request present |
| pri_ready | output | 1 | Primary request accepted this cycle |
| pri_addr | input | 32 | Primary-domain address |
| pri_write | input | 1 | 1 = write, 0 = read |
| pri_rid | input | 16 | Primary requester ID |
| pri_data | input | 32 | Write data |
| sec_valid | output | 1 | Translated request present |
| sec_ready | input | 1 | Secondary side takes the request |
| sec_addr | output | 32 | Secondary-domain address |
| sec_write | output | 1 | Forwarded write flag |
| sec_rid | output | 16 | Replacement requester ID |
| sec_data | output | 32 | Forwarded data |
| ur_valid | output | 1 | One-cycle unsupported-request strobe |
| ur_cause | output | 2 | 01 window miss, 10 ID miss |
| cfg_valid | input | 1 | Configuration write present |
| cfg_ready | output | 1 | Configuration slot free |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
Every result of the block is registered once:
- A forwarded request or an unsupported-request strobe becomes visible in the cycle that follows the rising edge that accepted the request.
- pri_ready and cfg_ready are combinational on the current state and sec_ready.
- A configuration write is captured on the edge that accepts it and applied on the first later edge with an empty output register. The first request that can see it is therefore accepted two edges after the write is taken, or later under back-pressure.

The bench advances a behavioural model on every rising edge. It compares all outputs 1 ns after every falling edge, so both the model and the design have settled on the same edge. Directed checks sample at exactly that point, one edge after acceptance.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // cause reported with an unsupported request
    typedef enum logic [1:0] {
        UR_NONE      = 2'b00,
        UR_NO_WINDOW = 2'b01,
        UR_NO_ID     = 2'b10
    } ur_cause_e;

    // configuration port geometry
    localparam int CFG_AW = 8;
    localparam int CFG_DW = 32;

    // region selector in cfg address bits [7:4]
    localparam logic [3:0] REGION_WIN = 4'h0;
    localparam logic [3:0] REGION_LUT = 4'h1;

    // control field layout
    localparam int CTL_EN_BIT = 0;
    localparam int CTL_LG_LSB = 8;

    // ID entry layout
    localparam int LUT_VALID_BIT = 16;

endpackage

// File: rtl/xlat_window_match.sv
module xlat_window_match #(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 4,
    parameter int CFG_DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_idx,
    input  logic [1:0]        wr_fld,
    input  logic [CFG_DW-1:0] wr_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_xaddr
);
    import xlat_pkg::*;

    localparam int LG_W = $clog2(ADDR_W);

    typedef struct packed {
        logic              en;
        logic [LG_W-1:0]   lg;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] tgt;
    } win_t;

    win_t win_d [NUM_WIN];
    win_t win_q [NUM_WIN];

    logic [NUM_WIN-1:0] hit_vec;
    logic [ADDR_W-1:0]  mask_v [NUM_WIN];

    // next-state: register writes
    always_comb begin
        for (int i = 0; i < NUM_WIN; i++) begin
            win_d[i] = win_q[i];
            if (wr_en && (wr_idx == 2'(i))) begin
                case (wr_fld)
                    2'd0: win_d[i].base = wr_data[ADDR_W-1:0];
                    2'd1: win_d[i].tgt  = wr_data[ADDR_W-1:0];
                    2'd2: begin
                        win_d[i].en = wr_data[CTL_EN_BIT];
                        win_d[i].lg = wr_data[CTL_LG_LSB +: LG_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WIN; i++) win_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_WIN; i++) win_q[i] <= win_d[i];
        end
    end

    // per-window comparators on the upper address bits
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign mask_v[g]  = {ADDR_W{1'b1}} << win_q[g].lg;
        assign hit_vec[g] = win_q[g].en &&
                            (((lk_addr ^ win_q[g].base) & mask_v[g]) == '0);

        // R8
        win_cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(win_q[g]) |-> $past(wr_en));
    end

    // lowest index wins
    always_comb begin
        lk_hit   = 1'b0;
        lk_xaddr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                lk_hit   = 1'b1;
                lk_xaddr = (win_q[i].tgt & mask_v[i]) | (lk_addr & ~mask_v[i]);
            end
        end
    end

    // R6
    win_hit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_vec) > 0 |-> lk_hit);

endmodule

// File: rtl/xlat_id_lut.sv
module xlat_id_lut #(
    parameter int RID_W  = 16,
    parameter int DEPTH  = 8,
    parameter int CFG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic              wr_sel,
    input  logic [CFG_DW-1:0] wr_data,
    input  logic [RID_W-1:0]  lk_rid,
    output logic              lk_hit,
    output logic [RID_W-1:0]  lk_xrid
);
    import xlat_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [RID_W-1:0] src;
        logic [RID_W-1:0] dst;
    } ent_t;

    ent_t ent_d [DEPTH];
    ent_t ent_q [DEPTH];

    logic [DEPTH-1:0] match_vec;
    logic [DEPTH-1:0] vld_vec;
    logic             unused_wdata;

    assign unused_wdata = ^wr_data[CFG_DW-1:LUT_VALID_BIT+1];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
            if (wr_en && (wr_idx == 3'(i))) begin
                if (!wr_sel) begin
                    ent_d[i].src = wr_data[RID_W-1:0];
                    ent_d[i].vld = wr_data[LUT_VALID_BIT];
                end else begin
                    ent_d[i].dst = wr_data[RID_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign vld_vec[g]   = ent_q[g].vld;
        assign match_vec[g] = ent_q[g].vld && (ent_q[g].src == lk_rid);

        // R8
        lut_cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ent_q[g]) |-> $past(wr_en));
    end

    always_comb begin
        lk_hit  = 1'b0;
        lk_xrid = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                lk_hit  = 1'b1;
                lk_xrid = ent_q[i].dst;
            end
        end
    end

    // R6
    lut_hit_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $countones(vld_vec) > 0);

endmodule

// File: rtl/xlat_bridge.sv
module xlat_bridge #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int RID_W     = 16,
    parameter int NUM_WIN   = 4,
    parameter int LUT_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_valid,
    output logic              pri_ready,
    input  logic [ADDR_W-1:0] pri_addr,
    input  logic              pri_write,
    input  logic [RID_W-1:0]  pri_rid,
    input  logic [DATA_W-1:0] pri_data,
    output logic              sec_valid,
    input  logic              sec_ready,
    output logic [ADDR_W-1:0] sec_addr,
    output logic              sec_write,
    output logic [RID_W-1:0]  sec_rid,
    output logic [DATA_W-1:0] sec_data,
    output logic              ur_valid,
    output logic [1:0]        ur_cause,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata
);
    import xlat_pkg::*;

    typedef struct packed {
        logic              sec_v;
        logic [ADDR_W-1:0] sec_addr;
        logic              sec_w;
        logic [RID_W-1:0]  sec_rid;
        logic [DATA_W-1:0] sec_data;
        logic              ur_v;
        ur_cause_e         ur_cause;
        logic              pend;
        logic [CFG_AW-1:0] p_addr;
        logic [CFG_DW-1:0] p_data;
    } st_t;

    st_t st_d, st_q;

    logic              apply;
    logic              win_wr, lut_wr;
    logic              win_hit, id_hit;
    logic [ADDR_W-1:0] x_addr;
    logic [RID_W-1:0]  x_rid;
    logic              pri_acc;

    assign pri_ready = !st_q.pend && (!st_q.sec_v || sec_ready);
    assign cfg_ready = !st_q.pend;
    assign pri_acc   = pri_valid && pri_ready;
    assign apply     = st_q.pend && !st_q.sec_v;
    assign win_wr    = apply && (st_q.p_addr[7:4] == REGION_WIN);
    assign lut_wr    = apply && (st_q.p_addr[7:4] == REGION_LUT);

    xlat_window_match #(
        .ADDR_W (ADDR_W),
        .NUM_WIN(NUM_WIN),
        .CFG_DW (CFG_DW)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (win_wr),
        .wr_idx  (st_q.p_addr[3:2]),
        .wr_fld  (st_q.p_addr[1:0]),
        .wr_data (st_q.p_data),
        .lk_addr (pri_addr),
        .lk_hit  (win_hit),
        .lk_xaddr(x_addr)
    );

    xlat_id_lut #(
        .RID_W (RID_W),
        .DEPTH (LUT_DEPTH),
        .CFG_DW(CFG_DW)
    ) u_lut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (lut_wr),
        .wr_idx (st_q.p_addr[3:1]),
        .wr_sel (st_q.p_addr[0]),
        .wr_data(st_q.p_data),
        .lk_rid (pri_rid),
        .lk_hit (id_hit),
        .lk_xrid(x_rid)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ur_v     = 1'b0;
        st_d.ur_cause = UR_NONE;
        if (st_q.sec_v && sec_ready) st_d.sec_v = 1'b0;
        if (apply) st_d.pend = 1'b0;
        if (cfg_valid && cfg_ready) begin
            st_d.pend   = 1'b1;
            st_d.p_addr = cfg_addr;
            st_d.p_data = cfg_wdata;
        end
        if (pri_acc) begin
            if (!win_hit) begin
                st_d.ur_v     = 1'b1;
                st_d.ur_cause = UR_NO_WINDOW;
            end else if (!id_hit) begin
                st_d.ur_v     = 1'b1;
                st_d.ur_cause = UR_NO_ID;
            end else begin
                st_d.sec_v    = 1'b1;
                st_d.sec_addr = x_addr;
                st_d.sec_w    = pri_write;
                st_d.sec_rid  = x_rid;
                st_d.sec_data = pri_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_valid = st_q.sec_v;
    assign sec_addr  = st_q.sec_addr;
    assign sec_write = st_q.sec_w;
    assign sec_rid   = st_q.sec_rid;
    assign sec_data  = st_q.sec_data;
    assign ur_valid  = st_q.ur_v;
    assign ur_cause  = st_q.ur_cause;

    // R9
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid && !sec_ready |=> sec_valid && $stable(sec_addr) &&
                                    $stable(sec_rid) && $stable(sec_data));

    // R8
    cfg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ready |=> !pri_ready && !cfg_ready);

    // R4
    ur_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ur_valid |-> $past(pri_valid && pri_ready));

    // R4
    ur_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ur_valid |-> !$rose(sec_valid));

    // R5
    ur_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ur_valid == (ur_cause != 2'b00));

endmodule

// File: tb/tb_xlat_bridge.sv
`timescale 1ns/1ps
module tb_xlat_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pri_valid = 1'b0, pri_write = 1'b0;
    logic [31:0] pri_addr = '0, pri_data = '0;
    logic [15:0] pri_rid = '0;
    logic        sec_ready = 1'b1;
    logic        cfg_valid = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pri_ready, sec_valid, sec_write, ur_valid, cfg_ready;
    logic [31:0] sec_addr, sec_data;
    logic [15:0] sec_rid;
    logic [1:0]  ur_cause;

    always #2.5 clk = ~clk;

    xlat_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .pri_valid(pri_valid), .pri_ready(pri_ready), .pri_addr(pri_addr),
        .pri_write(pri_write), .pri_rid(pri_rid), .pri_data(pri_data),
        .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_addr(sec_addr),
        .sec_write(sec_write), .sec_rid(sec_rid), .sec_data(sec_data),
        .ur_valid(ur_valid), .ur_cause(ur_cause),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    logic        m_sv, m_sw, m_ur, m_pend;
    logic [31:0] m_sa, m_sd, m_pd;
    logic [15:0] m_sr;
    logic [1:0]  m_uc;
    logic [7:0]  m_pa;
    logic [31:0] m_base [4], m_tgt [4];
    logic        m_en [4];
    int          m_lg [4];
    logic        m_lv [8];
    logic [15:0] m_ls [8], m_ld [8];

    always @(posedge clk) begin : model
        bit acc, capt, app;
        int hw, hl;
        longint span;
        if (!rst_n) begin
            m_sv = 0; m_sw = 0; m_ur = 0; m_pend = 0; m_sa = 0; m_sd = 0;
            m_pd = 0; m_sr = 0; m_uc = 0; m_pa = 0;
            for (int i = 0; i < 4; i++) begin
                m_base[i] = 0; m_tgt[i] = 0; m_en[i] = 0; m_lg[i] = 0;
            end
            for (int i = 0; i < 8; i++) begin
                m_lv[i] = 0; m_ls[i] = 0; m_ld[i] = 0;
            end
        end else begin
            acc  = pri_valid && !m_pend && (!m_sv || sec_ready);
            capt = cfg_valid && !m_pend;
            app  = m_pend && !m_sv;
            if (m_sv && sec_ready) m_sv = 0;
            m_ur = 0; m_uc = 0;
            if (acc) begin
                hw = -1;
                for (int w = 0; w < 4; w++)
                    if (hw < 0 && m_en[w] &&
                        ((pri_addr >> m_lg[w]) == (m_base[w] >> m_lg[w]))) hw = w;
                hl = -1;
                for (int i = 0; i < 8; i++)
                    if (hl < 0 && m_lv[i] && m_ls[i] == pri_rid) hl = i;
                if (hw < 0) begin
                    m_ur = 1; m_uc = 2'b01;
                end else if (hl < 0) begin
                    m_ur = 1; m_uc = 2'b10;
                end else begin
                    span = longint'(1) << m_lg[hw];
                    m_sa = 32'((longint'(m_tgt[hw]) / span) * span +
                               (longint'(pri_addr) % span));
                    m_sv = 1; m_sr = m_ld[hl]; m_sd = pri_data; m_sw = pri_write;
                end
            end
            if (app) begin
                if (m_pa[7:4] == 4'h0) begin
                    case (m_pa[1:0])
                        2'd0: m_base[m_pa[3:2]] = m_pd;
                        2'd1: m_tgt[m_pa[3:2]]  = m_pd;
                        2'd2: begin
                            m_en[m_pa[3:2]] = m_pd[0];
                            m_lg[m_pa[3:2]] = int'(m_pd[12:8]);
                        end
                        default: ;
                    endcase
                end else if (m_pa[7:4] == 4'h1) begin
                    if (!m_pa[0]) begin
                        m_lv[m_pa[3:1]] = m_pd[16];
                        m_ls[m_pa[3:1]] = m_pd[15:0];
                    end else begin
                        m_ld[m_pa[3:1]] = m_pd[15:0];
                    end
                end
                m_pend = 0;
            end
            if (capt) begin
                m_pend = 1; m_pa = cfg_addr; m_pd = cfg_wdata;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(pri_ready == (!m_pend && (!m_sv || sec_ready)), "R9", "pri_ready",
                pri_ready, !m_pend && (!m_sv || sec_ready));
            chk(cfg_ready == !m_pend, "R8", "cfg_ready", cfg_ready, !m_pend);
            chk(sec_valid == m_sv, "R1", "sec_valid", sec_valid, m_sv);
            if (m_sv) begin
                chk(sec_addr == m_sa, "R1", "sec_addr", sec_addr, m_sa);
                chk(sec_rid == m_sr, "R3", "sec_rid", sec_rid, m_sr);
                chk(sec_data == m_sd && sec_write == m_sw, "R3", "sec_data",
                    sec_data, m_sd);
            end
            chk(ur_valid == m_ur, "R4", "ur_valid", ur_valid, m_ur);
            chk(ur_cause == m_uc, "R5", "ur_cause", ur_cause, m_uc);
        end
    end

    // tasks start and end at a falling edge
    task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
        cfg_valid = 1; cfg_addr = a; cfg_wdata = d;
        #1;
        while (!cfg_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cfg_valid = 0;
    endtask

    task automatic send(input logic [31:0] a, input logic [15:0] rid,
                        input logic [31:0] d, input logic w);
        pri_valid = 1; pri_addr = a; pri_rid = rid; pri_data = d; pri_write = w;
        #1;
        while (!pri_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        pri_valid = 0;
    endtask

    // kind 0: forwarded, otherwise expected cause
    task automatic xfer(input logic [31:0] a, input logic [15:0] rid,
                        input logic [1:0] kind, input logic [31:0] exp_a,
                        input logic [15:0] exp_r, input string req);
        send(a, rid, a ^ 32'h5A5A_0000, a[2]);
        #1;
        if (kind == 2'b00) begin
            chk(sec_valid === 1'b1, req, "fwd valid", sec_valid, 1);
            chk(sec_addr === exp_a, req, "fwd addr", sec_addr, exp_a);
            chk(sec_rid === exp_r, req, "fwd rid", sec_rid, exp_r);
            chk(sec_data === (a ^ 32'h5A5A_0000) && sec_write === a[2], req,
                "fwd data", sec_data, a ^ 32'h5A5A_0000);
        end else begin
            chk(ur_valid === 1'b1 && sec_valid === 1'b0, req, "ur valid",
                ur_valid, 1);
            chk(ur_cause === kind, req, "ur cause", ur_cause, kind);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state
        chk(!sec_valid && !ur_valid, "R10", "outputs idle", {sec_valid, ur_valid}, 0);
        chk(pri_ready && cfg_ready, "R10", "ready", {pri_ready, cfg_ready}, 3);
        @(negedge clk);
        // R10 all windows disabled after reset
        xfer(32'h0000_8000, 16'h0101, 2'b01, 0, 0, "R10");

        // window0: base 0x8000, target 0x10000, 4 KiB
        cfg_wr(8'h00, 32'h0000_8000);
        cfg_wr(8'h01, 32'h0001_0000);
        cfg_wr(8'h02, 32'h0000_0C01);
        // ID entry 0: 0x0101 -> 0x0202
        cfg_wr(8'h10, 32'h0001_0101);
        cfg_wr(8'h11, 32'h0000_0202);

        // R1 R3 basic translation
        xfer(32'h0000_8040, 16'h0101, 2'b00, 32'h0001_0040, 16'h0202, "R1");
        xfer(32'h0000_8FFC, 16'h0101, 2'b00, 32'h0001_0FFC, 16'h0202, "R1");
        // R4 boundaries
        xfer(32'h0000_9000, 16'h0101, 2'b01, 0, 0, "R4");
        xfer(32'h0000_7FFC, 16'h0101, 2'b01, 0, 0, "R4");
        // R5 ID miss, and window miss priority
        xfer(32'h0000_8000, 16'h0303, 2'b10, 0, 0, "R5");
        xfer(32'h0000_9000, 16'h0303, 2'b01, 0, 0, "R5");

        // R7 unmapped addresses change nothing
        cfg_wr(8'h20, 32'h0000_0000);
        cfg_wr(8'h40, 32'h0000_0000);
        cfg_wr(8'h03, 32'h0000_0000);
        xfer(32'h0000_8040, 16'h0101, 2'b00, 32'h0001_0040, 16'h0202, "R7");

        // R1 R7 low base/target bits ignored: window2, 64 KiB
        cfg_wr(8'h08, 32'h0004_0123);
        cfg_wr(8'h09, 32'h0007_0FFF);
        cfg_wr(8'h0A, 32'h0000_1001);
        xfer(32'h0004_ABCD, 16'h0101, 2'b00, 32'h0007_ABCD, 16'h0202, "R1");

        // R2 overlap: window1 base 0x8000 target 0x20000, 256 B
        cfg_wr(8'h04, 32'h0000_8000);
        cfg_wr(8'h05, 32'h0002_0000);
        cfg_wr(8'h06, 32'h0000_0801);
        xfer(32'h0000_8010, 16'h0101, 2'b00, 32'h0001_0010, 16'h0202, "R2");
        // R6 disable window0
        cfg_wr(8'h02, 32'h0000_0C00);
        xfer(32'h0000_8010, 16'h0101, 2'b00, 32'h0002_0010, 16'h0202, "R6");
        xfer(32'h0000_8200, 16'h0101, 2'b01, 0, 0, "R6");
        cfg_wr(8'h02, 32'h0000_0C01);

        // R3 duplicate source: lowest entry wins
        cfg_wr(8'h12, 32'h0001_0101);
        cfg_wr(8'h13, 32'h0000_0999);
        xfer(32'h0000_8020, 16'h0101, 2'b00, 32'h0001_0020, 16'h0202, "R3");
        // R6 invalidate entry0
        cfg_wr(8'h10, 32'h0000_0101);
        xfer(32'h0000_8020, 16'h0101, 2'b00, 32'h0001_0020, 16'h0999, "R6");
        cfg_wr(8'h12, 32'h0000_0101);
        xfer(32'h0000_8020, 16'h0101, 2'b10, 0, 0, "R6");
        cfg_wr(8'h10, 32'h0001_0101);

        // R9 R8 back-pressure with a config write held behind it
        sec_ready = 0;
        send(32'h0000_8044, 16'h0101, 32'h1234_5678, 1'b1);
        #1;
        chk(sec_valid && sec_addr == 32'h0001_0044, "R9", "held addr", sec_addr,
            32'h0001_0044);
        @(negedge clk);
        pri_valid = 1; pri_addr = 32'h0000_8048; pri_rid = 16'h0101;
        pri_data = 32'h0BAD_F00D; pri_write = 1'b0;
        cfg_valid = 1; cfg_addr = 8'h01; cfg_wdata = 32'h0005_0000;
        #1;
        chk(!pri_ready, "R9", "pri_ready stalled", pri_ready, 0);
        chk(cfg_ready, "R8", "cfg slot free", cfg_ready, 1);
        @(negedge clk);
        cfg_valid = 0;
        #1;
        chk(!cfg_ready && !pri_ready, "R8", "pending stall", {cfg_ready, pri_ready}, 0);
        chk(sec_addr == 32'h0001_0044 && sec_data == 32'h1234_5678, "R9",
            "held stable", sec_addr, 32'h0001_0044);
        @(negedge clk);
        #1;
        chk(!cfg_ready, "R8", "still pending", cfg_ready, 0);
        @(negedge clk);
        sec_ready = 1;
        #1;
        chk(!pri_ready, "R8", "pri held by pending", pri_ready, 0);
        @(negedge clk);
        #1;
        chk(!sec_valid && !pri_ready, "R8", "drained, not applied",
            {sec_valid, pri_ready}, 0);
        @(negedge clk);
        #1;
        chk(pri_ready && cfg_ready, "R8", "applied", {pri_ready, cfg_ready}, 3);
        @(negedge clk);
        pri_valid = 0;
        #1;
        chk(sec_valid && sec_addr == 32'h0005_0048, "R8", "new target", sec_addr,
            32'h0005_0048);
        @(negedge clk);
        repeat (3) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule